// File: doc/BRIEF.md
# Registered 32-bit Integer ALU

This block is the arithmetic and logic stage of a simple integer pipeline. Each cycle it takes two operands and an already-decoded 4-bit operation code, and one clock edge later it presents the result word together with three flags: carry-out, signed overflow and zero. Ten operations are supported: add and subtract, each in a signed and an unsigned form; the four bitwise functions AND, OR, XOR and NOR; and two compare-and-set operations, one signed and one unsigned.

Subtraction uses the same adder as addition. The second operand is inverted bitwise and the carry into the least significant bit is forced to one. The adder is organised as fixed-size lookahead groups chained by group generate and propagate terms. Both compare operations run the subtractor and read its sign, overflow and carry terms. Immediate extension, instruction decoding and shifting happen elsewhere in the pipeline. Codes outside the ten listed produce an all-zero result with both arithmetic flags clear.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res_o`=0, `cout_o`=0, `ovf_o`=0 and `zero_o`=1.
- R2: Every output is registered: the values applied at one rising edge appear after that edge. For codes 4'h0 (signed add) and 4'h1 (unsigned add), `res_o` is (A+B) mod 2^WIDTH and `cout_o` is bit WIDTH of the full sum.
- R3: For codes 4'h2 (signed subtract) and 4'h3 (unsigned subtract), `res_o` is A+~B+1 mod 2^WIDTH and `cout_o` is the carry out of that sum, which is 1 exactly when A >= B as unsigned numbers.
- R4: For codes 4'h0 and 4'h2 only, `ovf_o` is the carry into the top bit XOR the carry out of it. This is 1 exactly when both effective addends have the same sign and the result has the other sign. An add of operands with opposite signs never flags.
- R5: `ovf_o` is 0 for every code other than 4'h0 and 4'h2, including the unsigned add and subtract.
- R6: Codes 4'h4, 4'h5, 4'h6 and 4'h7 give A AND B, A OR B, A XOR B and NOT(A OR B), with `cout_o`=0.
- R7: Code 4'hA (signed less-than) gives `res_o`=1 when A < B as two's-complement numbers, else 0. The answer is correct even when A-B overflows. Bits WIDTH-1..1 are zero and `cout_o`=0.
- R8: Code 4'hB (unsigned less-than) gives `res_o`=1 when A < B as unsigned numbers, else 0. Bits WIDTH-1..1 are zero and `cout_o`=0.
- R9: `zero_o` is 1 exactly when `res_o` is all zeros.
- R10: Codes 4'h8, 4'h9 and 4'hC to 4'hF give `res_o`=0, `cout_o`=0, `ovf_o`=0 and therefore `zero_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Decoded operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| res_o | output | WIDTH | Registered result |
| cout_o | output | 1 | Registered carry out of the add/subtract path |
| ovf_o | output | 1 | Registered signed overflow |
| zero_o | output | 1 | Registered all-zero result flag |

## Verification
The assertions assume that `op_i`, `a_i` and `b_i` hold known values at every rising edge after reset. They compare the outputs against a copy of those inputs captured at the edge, so the stimulus never leaves an input undriven and only changes inputs on the falling edge. The assertions make no assumption about which operation codes arrive, and the stimulus uses this freedom. It mixes directed corner operands (the most positive and most negative values, equal operands, and operand pairs whose difference overflows) with random operands under both valid and unused codes.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  // Operations that feed the adder an inverted second operand.
  function automatic logic op_inverts_b(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // Operations whose flags may report signed overflow.
  function automatic logic op_is_signed_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_opnd_prep.sv
`timescale 1ns/1ps
module alu_opnd_prep #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  import alu_pkg::*;

  logic inv;

  assign inv     = op_inverts_b(op_i);
  assign b_eff_o = inv ? ~b_i : b_i;
  assign cin_o   = inv;

endmodule

// File: rtl/alu_la_adder.sv
`timescale 1ns/1ps
// Two-level adder: bit carries inside a group, group generate/propagate
// terms between groups. WIDTH must be a multiple of GROUP.
module alu_la_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] bit_c;
  logic [NGRP:0]    grp_c;
  logic [NGRP-1:0]  grp_g;
  logic [NGRP-1:0]  grp_p;

  assign grp_c[0] = cin_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GROUP-1:0] gen;
    logic [GROUP-1:0] prp;
    logic [GROUP-1:0] lc;
    logic             gg;

    assign gen = x_i[gi*GROUP +: GROUP] & y_i[gi*GROUP +: GROUP];
    assign prp = x_i[gi*GROUP +: GROUP] ^ y_i[gi*GROUP +: GROUP];

    always_comb begin
      lc[0] = grp_c[gi];
      for (int j = 1; j < GROUP; j++) begin
        lc[j] = gen[j-1] | (prp[j-1] & lc[j-1]);
      end
    end

    always_comb begin
      gg = 1'b0;
      for (int j = 0; j < GROUP; j++) begin
        gg = gen[j] | (prp[j] & gg);
      end
    end

    assign grp_g[gi] = gg;
    assign grp_p[gi] = &prp;
    assign grp_c[gi+1] = grp_g[gi] | (grp_p[gi] & grp_c[gi]);

    assign bit_c[gi*GROUP +: GROUP] = lc;
    assign sum_o[gi*GROUP +: GROUP] = prp ^ lc;
  end

  assign c_msb_o = bit_c[WIDTH-1];
  assign cout_o  = grp_c[NGRP];

endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fn_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             zero_o
);
  import alu_pkg::*;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             c_msb;
  logic             c_out;
  logic [WIDTH-1:0] logic_y;
  logic             sgn_ovf;

  logic [WIDTH-1:0] res_d;
  logic             cout_d;
  logic             ovf_d;

  alu_opnd_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i    (op_i),
    .b_i     (b_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  alu_la_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
    .x_i     (a_i),
    .y_i     (b_eff),
    .cin_i   (cin),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .cout_o  (c_out)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .fn_i (op_i[1:0]),
    .a_i  (a_i),
    .b_i  (b_i),
    .y_o  (logic_y)
  );

  assign sgn_ovf = c_msb ^ c_out;

  always_comb begin
    res_d  = '0;
    cout_d = 1'b0;
    ovf_d  = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: begin
        res_d  = sum;
        cout_d = c_out;
        ovf_d  = op_is_signed_arith(op_i) & sgn_ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        res_d = logic_y;
      end
      OP_SLT: begin
        res_d[0] = sum[WIDTH-1] ^ sgn_ovf;
      end
      OP_SLTU: begin
        res_d[0] = ~c_out;
      end
      default: begin
        res_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      cout_o <= 1'b0;
      ovf_o  <= 1'b0;
      zero_o <= 1'b1;
    end else begin
      res_o  <= res_d;
      cout_o <= cout_d;
      ovf_o  <= ovf_d;
      zero_o <= ~|res_d;
    end
  end

endmodule

// File: rtl/int_alu_chk.sv
`timescale 1ns/1ps
module int_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o,
  input logic             ovf_o,
  input logic             zero_o
);
  import alu_pkg::*;

  logic             armed;
  logic [3:0]       op_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic             unused_q;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
    op_q <= op_i;
    a_q  <= a_i;
    b_q  <= b_i;
  end

  assign unused_q = (op_q == 4'h8) || (op_q == 4'h9) || (op_q >= 4'hC);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (zero_o == (res_o == '0)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_q != OP_ADD && op_q != OP_SUB) |-> !ovf_o);

  // R4
  mixed_sign_add_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_q == OP_ADD && a_q[WIDTH-1] != b_q[WIDTH-1]) |-> !ovf_o);

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (op_q == OP_ADD || op_q == OP_ADDU)) |-> (res_o == WIDTH'(a_q + b_q)));

  // R3
  sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (op_q == OP_SUB || op_q == OP_SUBU)) |-> (res_o == WIDTH'(a_q - b_q) && cout_o == (a_q >= b_q)));

  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_q >= OP_AND && op_q <= OP_NOR) |-> !cout_o);

  // R7
  slt_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_q == OP_SLT) |-> (res_o[WIDTH-1:1] == '0 && res_o[0] == ($signed(a_q) < $signed(b_q))));

  // R8
  sltu_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_q == OP_SLTU) |-> (res_o[WIDTH-1:1] == '0 && res_o[0] == (a_q < b_q)));

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && unused_q) |-> (res_o == '0 && !cout_o && !ovf_o && zero_o));

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .cout_o (cout_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
  localparam int W = 32;

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         c;
    logic         v;
    logic         z;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = 4'h0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] res_o;
  logic         cout_o, ovf_o, zero_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  int_alu uut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .cout_o(cout_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [W:0] s;
    e.op = op; e.res = '0; e.c = 1'b0; e.v = 1'b0;
    case (op)
      4'h0, 4'h1: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[W-1:0]; e.c = s[W];
        if (op == 4'h0) e.v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      end
      4'h2, 4'h3: begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        e.res = s[W-1:0]; e.c = s[W];
        if (op == 4'h2) e.v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
      end
      4'h4: e.res = a & b;
      4'h5: e.res = a | b;
      4'h6: e.res = a ^ b;
      4'h7: e.res = ~(a | b);
      4'hA: e.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'hB: e.res = {{(W-1){1'b0}}, (a < b)};
      default: e.res = '0;
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R6";
      4'hA: return "R7";
      4'hB: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    sb.push_back(model(op, a, b));
  endtask

  // monitor: compares each captured operation one edge later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(res_tag(e.op), "result", res_o, e.res);
        check((e.op <= 4'h3) ? ((e.op <= 4'h1) ? "R2" : "R3") : res_tag(e.op), "carry",
              {{(W-1){1'b0}}, cout_o}, {{(W-1){1'b0}}, e.c});
        check((e.op == 4'h0 || e.op == 4'h2) ? "R4" : "R5", "overflow",
              {{(W-1){1'b0}}, ovf_o}, {{(W-1){1'b0}}, e.v});
        check("R9", "zero", {{(W-1){1'b0}}, zero_o}, {{(W-1){1'b0}}, e.z});
      end
    end
  end

  // watchdog
  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with busy operands applied
    op_i = 4'h0; a_i = 32'hFFFF_FFFF; b_i = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset result", res_o, '0);
    check("R1", "reset carry", {31'b0, cout_o}, 32'b0);
    check("R1", "reset overflow", {31'b0, ovf_o}, 32'b0);
    check("R1", "reset zero", {31'b0, zero_o}, 32'b1);
    rst = 1'b0;

    // R2 / R4: add corners
    drive(4'h0, 32'h7FFF_FFFF, 32'h1);          // signed overflow
    drive(4'h1, 32'h7FFF_FFFF, 32'h1);          // unsigned: no overflow (R5)
    drive(4'h0, 32'h8000_0000, 32'h8000_0000);  // overflow with carry, zero result
    drive(4'h0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);  // opposite signs never overflow
    drive(4'h1, 32'hFFFF_FFFF, 32'h1);          // carry out, zero
    // R3: subtract corners
    drive(4'h2, 32'h8000_0000, 32'h1);          // overflow
    drive(4'h3, 32'h8000_0000, 32'h1);
    drive(4'h2, 32'h1234_5678, 32'h1234_5678);  // zero result, carry 1
    drive(4'h3, 32'h0, 32'h1);                  // borrow
    // R6 logic
    drive(4'h4, 32'hF0F0_A5A5, 32'hFF00_0F0F);
    drive(4'h5, 32'hF0F0_A5A5, 32'hFF00_0F0F);
    drive(4'h6, 32'hF0F0_A5A5, 32'hF0F0_A5A5);
    drive(4'h7, 32'h0, 32'h0);
    // R7 / R8 compares, including overflowing differences
    drive(4'hA, 32'h8000_0000, 32'h1);
    drive(4'hA, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    drive(4'hA, 32'hFFFF_FFFF, 32'h0);
    drive(4'hA, 32'h5, 32'h5);
    drive(4'hB, 32'h1, 32'hFFFF_FFFF);
    drive(4'hB, 32'hFFFF_FFFF, 32'h1);
    drive(4'hB, 32'h5, 32'h5);
    // R10 unused codes
    drive(4'h8, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(4'h9, 32'h8000_0000, 32'h8000_0000);
    for (int k = 12; k < 16; k++) drive(4'(k), 32'hDEAD_BEEF, 32'h1234_5678);

    // random mix over all sixteen codes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      drive(4'($urandom_range(0, 15)), ra, rb);
    end

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule